// File: doc/BRIEF.md
# Two-Channel Programmable Counter Array

This block shares one 16-bit free-running counter between two channels. The counter advances on a tick taken from one of several prescaler strobes, which are supplied from outside. A run control starts and stops it. An idle-stop control can also freeze it while the host reports idle. When the counter rolls over from all ones to zero it raises a sticky overflow flag. Software clears that flag, and it can be routed to the shared interrupt line.

Each channel reads a 7-bit configuration word and runs in one of five modes. In edge capture, selected edges of a synchronized input copy the whole counter into the channel's compare/capture register. In software timer, the channel flags the step that brings the counter to the 16-bit compare value. High-speed output does the same and also toggles the channel output. In PWM, the counter low byte is compared with a 9-bit duty value. That duty value is refreshed from a staging byte and staging bit each time the low byte rolls over. Every channel has a sticky flag and its own interrupt enable. All enabled sources are ORed into one interrupt output.

The counter control is a three-state machine. **CNT_STOP** moves to **CNT_RUN** when run is high and freeze is false. It moves to **CNT_FROZEN** when run is high and freeze is true. **CNT_RUN** moves to CNT_STOP when run drops, and to CNT_FROZEN when freeze becomes true. **CNT_FROZEN** moves to CNT_STOP when run drops, and to CNT_RUN when freeze becomes false. Freeze means idle-stop and host-idle are both high. The channel mode values are MD_OFF, MD_CAPTURE, MD_TIMER, MD_HSO and MD_PWM. They are decoded from the configuration word every cycle.

Top module: `pca_core`

## Requirements
- R1: The control state is updated on the clock edge after the run input changes. The counter then advances by exactly one on each clock edge where the state is CNT_RUN and `src_tick[src_sel]` is high. Otherwise the counter holds. The counter resets to 0.
- R2: `ovf_flag` is set on the same edge that the counter steps from 16'hFFFF to 16'h0000. It stays set until `ovf_clr` is sampled high. A roll-over and a clear on the same edge leave the flag set.
- R3: While `idle_stop` and `cpu_idle` are both high, the state becomes CNT_FROZEN and the counter holds. `cpu_idle` alone has no effect on counting.
- R4: The configuration bits are: bit0 interrupt enable, bit1 PWM, bit2 toggle, bit3 match, bit4 falling-edge capture, bit5 rising-edge capture, bit6 compare enable. Decoding follows this priority:
  - bits 6 and 1 give PWM;
  - bits 6, 3 and 2 give high-speed output;
  - bits 6 and 3 give software timer;
  - bit 5 or bit 4 gives capture;
  - anything else gives off.

  PWM without bit 6 is not PWM mode.
- R5: In capture mode, `cex_in` passes through two synchronizer flops before edge detection. A rising edge captures when bit 5 is set, and a falling edge captures when bit 4 is set. With both bits set, either edge captures. A capture copies all 16 counter bits into `cap_val` on one edge and sets the channel flag. An edge of a type that is not enabled changes neither.
- R6: In software-timer mode, the channel flag is set on the edge where the counter steps to the 16-bit compare value.
- R7: In high-speed-output mode, the same matching step also toggles `cex_out` for that channel. The output resets to 0.
- R8: In PWM mode, `cex_out` is 0 while {0, counter[7:0]} < {ext, compare[7:0]} and 1 otherwise. Over one 256-step window the output is therefore high for 256 − duty steps when ext is 0, and never high when ext is 1.
- R9: In PWM mode, the step that takes counter[7:0] from 8'hFF to 8'h00 copies compare[15:8] into compare[7:0] and copies `ext_shadow` into the active ext bit. Before that step the old duty still applies.
- R10: A channel flag stays set until its `flag_clr` bit is sampled. `irq` is high when `ovf_flag` and `ovf_ie` are both high, or when any channel has both its flag and its bit-0 enable set. With no flag set, `irq` is 0.
- R11: A `cmp_wr` pulse loads both bytes of that channel's compare register from `cmp_wdata`, and the value can be read on `cap_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 2 | Selects which tick strobe advances the counter |
| src_tick | input | 4 | Tick strobes from external prescalers |
| run | input | 1 | Counter run control |
| idle_stop | input | 1 | Freeze counter while host is idle |
| cpu_idle | input | 1 | Host idle indication |
| ovf_ie | input | 1 | Overflow interrupt enable |
| ovf_clr | input | 1 | Clears the overflow flag |
| mod_cfg | input | 2x7 | Per-channel configuration word |
| cmp_wr | input | 2 | Per-channel compare register write strobe |
| cmp_wdata | input | 2x16 | Per-channel compare write data |
| ext_shadow | input | 2 | Per-channel staged ninth duty bit |
| flag_clr | input | 2 | Per-channel flag clear |
| cex_in | input | 2 | Per-channel capture inputs (asynchronous) |
| cnt_val | output | 16 | Current counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| mod_flag | output | 2 | Sticky per-channel match/capture flags |
| cap_val | output | 2x16 | Per-channel compare/capture register |
| cex_out | output | 2 | Per-channel toggle or PWM output |
| irq | output | 1 | Combined interrupt |

## Verification
The properties assume several things about the inputs.
- No source other than a single step moves the counter.
- `run`, `idle_stop` and `cpu_idle` are synchronous levels, so a hold can be checked two cycles after the stopping condition is seen.
- Flags are only cleared through their explicit clear inputs.

The stimulus respects all of this. It changes every input only at the falling clock edge. It stops the counter before each capture so that the captured value is known exactly. It also moves `cex_in` only when enough cycles remain for the synchronizer to settle.

// File: rtl/pca_pkg.sv
package pca_pkg;
    localparam int CFG_W   = 7;
    localparam int CB_IE   = 0;
    localparam int CB_PWM  = 1;
    localparam int CB_TOG  = 2;
    localparam int CB_MAT  = 3;
    localparam int CB_CAPN = 4;
    localparam int CB_CAPP = 5;
    localparam int CB_ECOM = 6;

    typedef enum logic [1:0] {
        CNT_STOP   = 2'd0,
        CNT_RUN    = 2'd1,
        CNT_FROZEN = 2'd2
    } cnt_state_e;

    typedef enum logic [2:0] {
        MD_OFF     = 3'd0,
        MD_CAPTURE = 3'd1,
        MD_TIMER   = 3'd2,
        MD_HSO     = 3'd3,
        MD_PWM     = 3'd4
    } mod_mode_e;

    // Priority decode of a channel configuration word (R4)
    function automatic mod_mode_e decode_mode(input logic [CFG_W-1:0] c);
        if (c[CB_ECOM] && c[CB_PWM])
            return MD_PWM;
        else if (c[CB_ECOM] && c[CB_MAT] && c[CB_TOG])
            return MD_HSO;
        else if (c[CB_ECOM] && c[CB_MAT])
            return MD_TIMER;
        else if (c[CB_CAPP] || c[CB_CAPN])
            return MD_CAPTURE;
        else
            return MD_OFF;
    endfunction
endpackage

// File: rtl/pca_counter.sv
module pca_counter
    import pca_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NSRC  = 4,
    localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int LO_W  = CNT_W / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] src_sel,
    input  logic [NSRC-1:0]  src_tick,
    input  logic             run,
    input  logic             idle_stop,
    input  logic             cpu_idle,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] cnt_q,
    output logic             step,
    output logic             lo_wrap,
    output logic             ovf_flag
);
    cnt_state_e st_q, st_d;
    logic       freeze;
    logic       tick_sel;
    logic       ovf_ev;

    assign freeze = idle_stop && cpu_idle;

    always_comb begin
        tick_sel = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (src_sel == SEL_W'(i)) tick_sel = src_tick[i];
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CNT_STOP;
        else        st_q <= st_d;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CNT_STOP: begin
                if (run) st_d = freeze ? CNT_FROZEN : CNT_RUN;
            end
            CNT_RUN: begin
                if (!run)        st_d = CNT_STOP;
                else if (freeze) st_d = CNT_FROZEN;
            end
            CNT_FROZEN: begin
                if (!run)         st_d = CNT_STOP;
                else if (!freeze) st_d = CNT_RUN;
            end
            default: st_d = CNT_STOP;
        endcase
    end

    // Output decode
    always_comb begin
        step = 1'b0;
        unique case (st_q)
            CNT_RUN:    step = tick_sel;
            CNT_STOP,
            CNT_FROZEN: step = 1'b0;
            default:    step = 1'b0;
        endcase
    end

    assign lo_wrap = step && (cnt_q[LO_W-1:0] == '1);
    assign ovf_ev  = step && (cnt_q == '1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            ovf_flag <= 1'b0;
        end else begin
            if (step) cnt_q <= cnt_q + CNT_W'(1);
            if (ovf_ev)       ovf_flag <= 1'b1;
            else if (ovf_clr) ovf_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/pca_channel.sv
module pca_channel
    import pca_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int LO_W = CNT_W / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic             step,
    input  logic             lo_wrap,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             ext_shadow,
    input  logic             flag_clr,
    input  logic             cex_in,
    output logic [CNT_W-1:0] cmp_q,
    output logic             flag,
    output logic             cex_out,
    output logic             irq_req
);
    mod_mode_e        mode;
    logic [2:0]       sync_q;
    logic             rise, fall;
    logic [CNT_W-1:0] cnt_nxt;
    logic             hit, cap_ev, tog_ev, reload;
    logic             ext_q;
    logic             hso_q;
    logic             pwm_hi;

    assign mode    = decode_mode(cfg);
    assign cnt_nxt = cnt_q + CNT_W'(1);

    // Two synchronizer flops plus one history flop for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], cex_in};
    end
    assign rise = sync_q[1] && !sync_q[2];
    assign fall = !sync_q[1] && sync_q[2];

    // Mode-dependent event generation
    always_comb begin
        hit    = 1'b0;
        cap_ev = 1'b0;
        tog_ev = 1'b0;
        reload = 1'b0;
        unique case (mode)
            MD_CAPTURE: cap_ev = (cfg[CB_CAPP] && rise) || (cfg[CB_CAPN] && fall);
            MD_TIMER:   hit    = step && (cnt_nxt == cmp_q);
            MD_HSO: begin
                hit    = step && (cnt_nxt == cmp_q);
                tog_ev = step && (cnt_nxt == cmp_q);
            end
            MD_PWM:     reload = lo_wrap;
            MD_OFF:     hit    = 1'b0;
            default:    hit    = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
            ext_q <= 1'b0;
            flag  <= 1'b0;
            hso_q <= 1'b0;
        end else begin
            if (cmp_wr)      cmp_q <= cmp_wdata;
            else if (cap_ev) cmp_q <= cnt_q;
            else if (reload) cmp_q[LO_W-1:0] <= cmp_q[CNT_W-1:LO_W];
            if (reload) ext_q <= ext_shadow;
            if (hit || cap_ev) flag <= 1'b1;
            else if (flag_clr) flag <= 1'b0;
            if (tog_ev) hso_q <= !hso_q;
        end
    end

    assign pwm_hi  = {1'b0, cnt_q[LO_W-1:0]} >= {ext_q, cmp_q[LO_W-1:0]};
    assign cex_out = (mode == MD_PWM) ? pwm_hi : hso_q;
    assign irq_req = flag && cfg[CB_IE];
endmodule

// File: rtl/pca_core.sv
module pca_core
    import pca_pkg::*;
#(
    parameter int NMOD  = 2,
    parameter int CNT_W = 16,
    parameter int NSRC  = 4,
    localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SEL_W-1:0]           src_sel,
    input  logic [NSRC-1:0]            src_tick,
    input  logic                       run,
    input  logic                       idle_stop,
    input  logic                       cpu_idle,
    input  logic                       ovf_ie,
    input  logic                       ovf_clr,
    input  logic [NMOD-1:0][CFG_W-1:0] mod_cfg,
    input  logic [NMOD-1:0]            cmp_wr,
    input  logic [NMOD-1:0][CNT_W-1:0] cmp_wdata,
    input  logic [NMOD-1:0]            ext_shadow,
    input  logic [NMOD-1:0]            flag_clr,
    input  logic [NMOD-1:0]            cex_in,
    output logic [CNT_W-1:0]           cnt_val,
    output logic                       ovf_flag,
    output logic [NMOD-1:0]            mod_flag,
    output logic [NMOD-1:0][CNT_W-1:0] cap_val,
    output logic [NMOD-1:0]            cex_out,
    output logic                       irq
);
    logic            step;
    logic            lo_wrap;
    logic [NMOD-1:0] mod_irq;

    pca_counter #(.CNT_W(CNT_W), .NSRC(NSRC)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_sel  (src_sel),
        .src_tick (src_tick),
        .run      (run),
        .idle_stop(idle_stop),
        .cpu_idle (cpu_idle),
        .ovf_clr  (ovf_clr),
        .cnt_q    (cnt_val),
        .step     (step),
        .lo_wrap  (lo_wrap),
        .ovf_flag (ovf_flag)
    );

    for (genvar g = 0; g < NMOD; g++) begin : g_ch
        pca_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg       (mod_cfg[g]),
            .cnt_q     (cnt_val),
            .step      (step),
            .lo_wrap   (lo_wrap),
            .cmp_wr    (cmp_wr[g]),
            .cmp_wdata (cmp_wdata[g]),
            .ext_shadow(ext_shadow[g]),
            .flag_clr  (flag_clr[g]),
            .cex_in    (cex_in[g]),
            .cmp_q     (cap_val[g]),
            .flag      (mod_flag[g]),
            .cex_out   (cex_out[g]),
            .irq_req   (mod_irq[g])
        );
    end

    assign irq = (ovf_flag && ovf_ie) || (|mod_irq);
endmodule

// File: rtl/pca_checker.sv
module pca_checker #(
    parameter int NMOD  = 2,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             idle_stop,
    input logic             cpu_idle,
    input logic             ovf_clr,
    input logic [NMOD-1:0]  flag_clr,
    input logic [CNT_W-1:0] cnt_val,
    input logic             ovf_flag,
    input logic [NMOD-1:0]  mod_flag,
    input logic             irq
);
    // R1: the counter only ever moves forward by one
    p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_val) |-> cnt_val == CNT_W'($past(cnt_val) + 1'b1));

    // R1: a low run input halts the counter after the control state catches up
    p_cnt_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> ##2 $stable(cnt_val));

    // R3: idle freeze halts the counter
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_stop && cpu_idle) |-> ##2 $stable(cnt_val));

    // R2: roll-over raises the overflow flag
    p_ovf_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_val == '1) ##1 (cnt_val == '0) |-> ovf_flag);

    // R2: overflow flag is sticky until cleared
    p_ovf_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    // R10: no pending flag means no interrupt
    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_flag && mod_flag == '0) |-> !irq);

    for (genvar g = 0; g < NMOD; g++) begin : g_flag
        // R10: channel flag is sticky until cleared
        p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (mod_flag[g] && !flag_clr[g]) |=> mod_flag[g]);
    end
endmodule

bind pca_core pca_checker #(.NMOD(NMOD), .CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .idle_stop(idle_stop),
    .cpu_idle (cpu_idle),
    .ovf_clr  (ovf_clr),
    .flag_clr (flag_clr),
    .cnt_val  (cnt_val),
    .ovf_flag (ovf_flag),
    .mod_flag (mod_flag),
    .irq      (irq)
);

// File: tb/pca_core_tb_top.sv
module pca_core_tb_top;
    import pca_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NMOD  = 2;
    localparam int CNT_W = 16;
    localparam int NSRC  = 4;
    localparam int WATCHDOG = 190000;
    localparam int NVEC = 6;
    // {ext, duty, expected high steps per 256-step window}
    localparam logic [17:0] PWM_VEC [NVEC] = '{
        {1'b0, 8'h00, 9'd256},
        {1'b0, 8'h80, 9'd128},
        {1'b0, 8'hFF, 9'd1},
        {1'b1, 8'h00, 9'd0},
        {1'b1, 8'h40, 9'd0},
        {1'b0, 8'h01, 9'd255}
    };

    logic                       clk = 1'b0;
    logic                       rst_n;
    logic [1:0]                 src_sel;
    logic [NSRC-1:0]            src_tick;
    logic                       run, idle_stop, cpu_idle, ovf_ie, ovf_clr;
    logic [NMOD-1:0][CFG_W-1:0] mod_cfg;
    logic [NMOD-1:0]            cmp_wr;
    logic [NMOD-1:0][CNT_W-1:0] cmp_wdata;
    logic [NMOD-1:0]            ext_shadow, flag_clr, cex_in;
    logic [CNT_W-1:0]           cnt_val;
    logic                       ovf_flag;
    logic [NMOD-1:0]            mod_flag;
    logic [NMOD-1:0][CNT_W-1:0] cap_val;
    logic [NMOD-1:0]            cex_out;
    logic                       irq;

    int n_chk  = 0;
    int n_fail = 0;

    pca_core #(.NMOD(NMOD), .CNT_W(CNT_W), .NSRC(NSRC)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .src_tick(src_tick),
        .run(run), .idle_stop(idle_stop), .cpu_idle(cpu_idle),
        .ovf_ie(ovf_ie), .ovf_clr(ovf_clr), .mod_cfg(mod_cfg),
        .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .ext_shadow(ext_shadow),
        .flag_clr(flag_clr), .cex_in(cex_in), .cnt_val(cnt_val),
        .ovf_flag(ovf_flag), .mod_flag(mod_flag), .cap_val(cap_val),
        .cex_out(cex_out), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cmp(input int ch, input logic [15:0] v);
        cmp_wr[ch] = 1'b1; cmp_wdata[ch] = v;
        cyc(1);
        cmp_wr[ch] = 1'b0;
    endtask

    task automatic clear_flags();
        flag_clr = '1; ovf_clr = 1'b1;
        cyc(1);
        flag_clr = '0; ovf_clr = 1'b0;
    endtask

    task automatic halt();
        run = 1'b0;
        cyc(3);
    endtask

    initial begin
        cyc(WATCHDOG);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] c, c2, c3;
        int highs;
        rst_n = 1'b0; src_sel = '0; src_tick = '0; run = 0; idle_stop = 0; cpu_idle = 0;
        ovf_ie = 0; ovf_clr = 0; mod_cfg = '0; cmp_wr = '0; cmp_wdata = '0;
        ext_shadow = '0; flag_clr = '0; cex_in = '0;
        cyc(5);
        rst_n = 1'b1;
        cyc(1);
        check("R1 reset count", cnt_val, 0);
        check("R2 reset ovf", ovf_flag, 0);
        check("R10 reset flags/irq", {mod_flag, irq}, 0);
        check("R7 reset outputs", cex_out, 0);
        check("R11 reset compare", cap_val, 0);

        // R1: start-up latency and counting
        src_tick = 4'b0001; run = 1'b1;
        cyc(10);
        check("R1 count after 10 edges", cnt_val, 9);
        // R1: source select picks an idle strobe
        src_sel = 2'd1;
        c = cnt_val;
        cyc(5);
        check("R1 unselected strobe idle", cnt_val, c);
        src_tick = 4'b0010;
        cyc(4);
        check("R1 selected strobe counts", cnt_val, c + 4);

        // R3: idle freeze
        idle_stop = 1'b1; cpu_idle = 1'b1;
        cyc(1);
        c = cnt_val;
        cyc(6);
        check("R3 frozen while idle", cnt_val, c);
        cpu_idle = 1'b0;
        cyc(5);
        check("R3 resumes after idle", cnt_val, c + 4);
        idle_stop = 1'b0; cpu_idle = 1'b1;
        c = cnt_val;
        cyc(5);
        check("R3 idle alone ignored", cnt_val, c + 5);
        cpu_idle = 1'b0;

        // R6/R11: software timer on channel 0
        halt();
        c = cnt_val;
        mod_cfg[0] = '0; mod_cfg[0][CB_ECOM] = 1'b1; mod_cfg[0][CB_MAT] = 1'b1;
        write_cmp(0, c + 16'd7);
        check("R11 compare readback", cap_val[0], c + 16'd7);
        run = 1'b1;
        for (int k = 0; k < 40 && !mod_flag[0]; k++) cyc(1);
        check("R6 flag at match step", cnt_val, c + 16'd7);
        check("R10 irq masked", irq, 0);
        mod_cfg[0][CB_IE] = 1'b1;
        #1;
        check("R10 irq enabled", irq, 1);
        clear_flags();
        check("R10 flag cleared", {mod_flag[0], irq}, 0);

        // R7: high-speed output on channel 1
        c = cnt_val;
        mod_cfg[1] = '0; mod_cfg[1][CB_ECOM] = 1'b1; mod_cfg[1][CB_MAT] = 1'b1; mod_cfg[1][CB_TOG] = 1'b1;
        write_cmp(1, c + 16'd20);
        check("R7 output low before match", cex_out[1], 0);
        for (int k = 0; k < 60 && !cex_out[1]; k++) cyc(1);
        check("R7 toggle at match step", cnt_val, c + 16'd20);
        check("R7 flag with toggle", mod_flag[1], 1);
        mod_cfg[0] = '0;

        // R5: capture on channel 0
        halt();
        clear_flags();
        c = cnt_val;
        mod_cfg[0][CB_CAPP] = 1'b1;
        cex_in[0] = 1'b1;
        cyc(5);
        check("R5 rising capture value", cap_val[0], c);
        check("R5 rising capture flag", mod_flag[0], 1);
        mod_cfg[0] = '0; cex_in[0] = 1'b0;
        clear_flags();
        run = 1'b1; cyc(10); halt();
        c2 = cnt_val;
        mod_cfg[0][CB_CAPN] = 1'b1;
        cex_in[0] = 1'b1;
        cyc(5);
        check("R5 rising ignored in falling mode", {mod_flag[0], cap_val[0]}, {1'b0, c});
        cex_in[0] = 1'b0;
        cyc(5);
        check("R5 falling capture", {mod_flag[0], cap_val[0]}, {1'b1, c2});
        clear_flags();
        run = 1'b1; cyc(7); halt();
        c3 = cnt_val;
        mod_cfg[0][CB_CAPP] = 1'b1;
        cex_in[0] = 1'b1;
        cyc(5);
        check("R5 both-edge capture", {mod_flag[0], cap_val[0]}, {1'b1, c3});
        mod_cfg[0] = '0;
        clear_flags();

        // R4: PWM bit without compare enable does not select PWM
        run = 1'b1;
        mod_cfg[1] = '0; mod_cfg[1][CB_PWM] = 1'b1;
        cyc(300);
        check("R4 PWM needs compare enable", cex_out[1], 1);

        // R9: duty reload at low-byte wrap
        mod_cfg[1][CB_ECOM] = 1'b1;
        ext_shadow[1] = 1'b0;
        for (int k = 0; k < 300 && cnt_val[7:0] != 8'h10; k++) cyc(1);
        write_cmp(1, 16'h40C0);
        for (int k = 0; k < 300 && cnt_val[7:0] != 8'h80; k++) cyc(1);
        check("R9 old duty before wrap", cex_out[1], 0);
        for (int k = 0; k < 300 && cnt_val[7:0] != 8'h00; k++) cyc(1);
        for (int k = 0; k < 300 && cnt_val[7:0] != 8'h80; k++) cyc(1);
        check("R9 new duty after wrap", cex_out[1], 1);
        check("R9 low byte reloaded", cap_val[1], 16'h4040);

        // R8: duty table
        for (int v = 0; v < NVEC; v++) begin
            ext_shadow[1] = PWM_VEC[v][17];
            write_cmp(1, {PWM_VEC[v][16:9], PWM_VEC[v][16:9]});
            cyc(300);
            highs = 0;
            for (int k = 0; k < 256; k++) begin
                cyc(1);
                if (cex_out[1]) highs++;
            end
            check($sformatf("R8 duty vector %0d", v), highs, PWM_VEC[v][8:0]);
        end

        // R2: overflow
        mod_cfg = '0;
        ext_shadow = '0;
        clear_flags();
        for (int k = 0; k < 70000 && cnt_val != 16'hFFFF; k++) cyc(1);
        check("R2 flag clear before roll-over", ovf_flag, 0);
        cyc(1);
        check("R2 roll-over value", cnt_val, 0);
        check("R2 flag on roll-over", ovf_flag, 1);
        check("R10 ovf irq masked", irq, 0);
        cyc(5);
        check("R2 flag sticky", ovf_flag, 1);
        ovf_ie = 1'b1;
        #1;
        check("R10 ovf irq enabled", irq, 1);
        ovf_clr = 1'b1;
        cyc(1);
        ovf_clr = 1'b0;
        check("R2 flag cleared", {ovf_flag, irq}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule